// File: doc/BRIEF.md
# Burst DMA Handshake Controller

This block is the device-side handshake engine of a counter-driven DMA path. Software programs a byte count, a burst length in bytes, the data bus width (16 or 32 bits), the active levels of the request output and the acknowledge input, and the endpoint whose buffer is served. A read or write start command then launches one transfer. The block drives the request line, counts the acknowledged bus cycles against a byte counter, and drops the request between bursts. When the byte counter is exhausted it ends the transfer and raises a completion flag.

Only one endpoint is served per transfer. The endpoint number and the direction are captured at the start command, so later register writes cannot reroute a transfer that is running. The byte count register is meant to be written again before every transfer. A start command that arrives while a transfer runs is dropped.

Top module: `dma_burst_hs`

Register write port (`cfg_addr`): 0 = byte count, 1 = burst length (bytes, low 8 bits), 2 = mode (bit0: 1 selects 32-bit bus, 0 selects 16-bit bus; bit1: request active low; bit2: acknowledge active low), 3 = endpoint number, 4 = command (bit0 read start, bit1 write start), 5 = status (bit0 written as 1 clears the done flag).

## Requirements
- R1: After reset, busy and done are 0, bytes_left is 0, and dma_req sits at its inactive level.
- R2: A write to address 4 with bit0 or bit1 set, while idle and with a nonzero count, makes busy 1 and the request active from the next cycle, loads bytes_left with the count, and captures ep_sel from address 3 and xfer_dir_wr from bit1 (bit1 set means write).
- R3: Each clock edge with the acknowledge active while the request is active lowers bytes_left by 4 (mode bit0 = 1) or 2 (mode bit0 = 0), stopping at 0; an acknowledge while the request is inactive changes nothing.
- R4: When a burst of ceil(B/W) accepted beats ends (B is the effective burst length, W the bus width in bytes) and bytes remain, the request goes inactive for exactly one cycle and then becomes active again.
- R5: When bytes_left reaches 0 the request goes inactive, busy clears and done sets in that same cycle, even in the middle of a burst.
- R6: A programmed burst length below the bus width in bytes is raised to the bus width, so the burst is a single beat and the request toggles every cycle.
- R7: Mode bit1 set makes dma_req active low; mode bit2 set makes dma_ack active low.
- R8: A start command while busy is ignored: bytes_left, xfer_dir_wr and the running transfer are unchanged.
- R9: Writing address 5 with bit0 = 1 clears done; writing it with bit0 = 0 leaves done set.
- R10: A start command with a byte count of 0 sets done at once, leaves busy at 0, and never activates the request.
- R11: Writing the endpoint register during a transfer does not change ep_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | CNT_W | Register write data |
| dma_ack | input | 1 | DMA acknowledge, level set by mode bit2 |
| dma_req | output | 1 | DMA request, level set by mode bit1 |
| busy | output | 1 | A transfer is running |
| done | output | 1 | Completion flag, cleared by write-one |
| xfer_dir_wr | output | 1 | Direction of the current or last transfer (1 = write) |
| ep_sel | output | EP_W | Endpoint routed to the DMA bus |
| bytes_left | output | CNT_W | Remaining byte count |

## Verification
A wrong byte counter shows as a wrong bytes_left one cycle after the faulty beat and as early or late completion, which the bench sees as a beat count that differs from ceil(count/W). A wrong burst counter shows as request gaps in the wrong places, so the number of request activations per transfer differs from the expected burst count within the first burst. A polarity or acknowledge-gating fault shows at once as a request at the wrong level or as a decrement during a gap cycle.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_COUNT = 3'd0;
  localparam logic [ADDR_W-1:0] RA_BURST = 3'd1;
  localparam logic [ADDR_W-1:0] RA_MODE  = 3'd2;
  localparam logic [ADDR_W-1:0] RA_EP    = 3'd3;
  localparam logic [ADDR_W-1:0] RA_CMD   = 3'd4;
  localparam logic [ADDR_W-1:0] RA_STAT  = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_GAP  = 2'd2
  } hs_state_t;

  typedef struct packed {
    logic ack_inv;
    logic req_inv;
    logic bus32;
  } hs_mode_t;
endpackage

// File: rtl/dma_hs_regs.sv
module dma_hs_regs
  import dma_hs_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BURST_W = 8,
  parameter int EP_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   count_q,
  output logic [BURST_W-1:0] burst_q,
  output hs_mode_t           mode_q,
  output logic [EP_W-1:0]    ep_q,
  output logic               go_rd,
  output logic               go_wr,
  output logic               done_clr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      burst_q <= '0;
      mode_q  <= '0;
      ep_q    <= '0;
    end else if (we) begin
      case (addr)
        RA_COUNT: count_q <= wdata;
        RA_BURST: burst_q <= wdata[BURST_W-1:0];
        RA_MODE:  mode_q  <= hs_mode_t'(wdata[2:0]);
        RA_EP:    ep_q    <= wdata[EP_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    go_rd    = we && (addr == RA_CMD) && wdata[0];
    go_wr    = we && (addr == RA_CMD) && wdata[1];
    done_clr = we && (addr == RA_STAT) && wdata[0];
  end
endmodule

// File: rtl/dma_hs_downcnt.sv
module dma_hs_downcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  input  logic [W-1:0] step,
  output logic [W-1:0] value,
  output logic         last
);
  assign last = (value <= step);

  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (load) value <= load_val;
    else if (dec)  value <= last ? '0 : value - step;
  end
endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
  import dma_hs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go_rd,
  input  logic go_wr,
  input  logic count_zero,
  input  logic ack_act,
  input  logic byte_last,
  input  logic burst_last,
  input  logic done_clr,
  output logic req_act,
  output logic busy,
  output logic done,
  output logic dir_wr,
  output logic load_all,
  output logic load_burst,
  output logic dec
);
  hs_state_t state, nxt;
  logic      done_set;

  always_comb begin
    nxt        = state;
    load_all   = 1'b0;
    load_burst = 1'b0;
    dec        = 1'b0;
    done_set   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (go_rd || go_wr) begin
          if (count_zero) begin
            done_set = 1'b1;
          end else begin
            load_all = 1'b1;
            nxt      = ST_BEAT;
          end
        end
      end
      ST_BEAT: begin
        if (ack_act) begin
          dec = 1'b1;
          if (byte_last) begin
            done_set = 1'b1;
            nxt      = ST_IDLE;
          end else if (burst_last) begin
            nxt = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        load_burst = 1'b1;
        nxt        = ST_BEAT;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      dir_wr <= 1'b0;
    end else begin
      state <= nxt;
      if (done_set)      done <= 1'b1;
      else if (done_clr) done <= 1'b0;
      if (load_all)      dir_wr <= go_wr;
    end
  end

  assign req_act = (state == ST_BEAT);
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/dma_burst_hs.sv
module dma_burst_hs
  import dma_hs_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BURST_W = 8,
  parameter int EP_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             dma_ack,
  output logic             dma_req,
  output logic             busy,
  output logic             done,
  output logic             xfer_dir_wr,
  output logic [EP_W-1:0]  ep_sel,
  output logic [CNT_W-1:0] bytes_left
);
  localparam int WIDE_BYTES   = 4;
  localparam int NARROW_BYTES = 2;

  logic [CNT_W-1:0]   count_q;
  logic [BURST_W-1:0] burst_q;
  hs_mode_t           mode_q;
  logic [EP_W-1:0]    ep_q;
  logic               go_rd, go_wr, done_clr;
  logic               req_act, ack_act;
  logic               load_all, load_burst, dec;
  logic               byte_last, burst_last;
  logic [CNT_W-1:0]   step;
  logic [BURST_W-1:0] step_b;
  logic [BURST_W-1:0] eff_burst;
  logic [BURST_W-1:0] burst_left;

  dma_hs_regs #(.CNT_W(CNT_W), .BURST_W(BURST_W), .EP_W(EP_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .count_q(count_q), .burst_q(burst_q), .mode_q(mode_q), .ep_q(ep_q),
    .go_rd(go_rd), .go_wr(go_wr), .done_clr(done_clr)
  );

  assign step      = mode_q.bus32 ? CNT_W'(WIDE_BYTES) : CNT_W'(NARROW_BYTES);
  assign step_b    = mode_q.bus32 ? BURST_W'(WIDE_BYTES) : BURST_W'(NARROW_BYTES);
  assign eff_burst = (burst_q < step_b) ? step_b : burst_q;
  assign ack_act   = dma_ack ^ mode_q.ack_inv;

  dma_hs_downcnt #(.W(CNT_W)) u_bytes (
    .clk(clk), .rst(rst), .load(load_all), .load_val(count_q),
    .dec(dec), .step(step), .value(bytes_left), .last(byte_last)
  );

  dma_hs_downcnt #(.W(BURST_W)) u_burst (
    .clk(clk), .rst(rst), .load(load_all || load_burst), .load_val(eff_burst),
    .dec(dec), .step(step_b), .value(burst_left), .last(burst_last)
  );

  dma_hs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .go_rd(go_rd), .go_wr(go_wr),
    .count_zero(count_q == '0), .ack_act(ack_act),
    .byte_last(byte_last), .burst_last(burst_last), .done_clr(done_clr),
    .req_act(req_act), .busy(busy), .done(done), .dir_wr(xfer_dir_wr),
    .load_all(load_all), .load_burst(load_burst), .dec(dec)
  );

  always_ff @(posedge clk) begin
    if (rst)           ep_sel <= '0;
    else if (load_all) ep_sel <= ep_q;
  end

  assign dma_req = req_act ^ mode_q.req_inv;
endmodule

// File: rtl/dma_hs_chk.sv
module dma_hs_chk #(
  parameter int CNT_W = 16,
  parameter int EP_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             req_act,
  input logic             ack_act,
  input logic             cfg_we,
  input logic [2:0]       cfg_addr,
  input logic [CNT_W-1:0] cfg_wdata,
  input logic [CNT_W-1:0] step,
  input logic [CNT_W-1:0] bytes_left,
  input logic [EP_W-1:0]  ep_sel
);
  p_accept_decrements_r3: assert property (@(posedge clk) disable iff (rst)
    (req_act && ack_act && bytes_left > step) |=> (bytes_left == $past(bytes_left) - $past(step)));

  p_idle_holds_count_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (busy || $stable(bytes_left)));

  p_gap_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(req_act) && busy) |=> req_act);

  p_finish_state_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && $past(busy)) |-> (!busy && !req_act && bytes_left == '0));

  p_clear_by_write_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(cfg_we && cfg_addr == 3'd5 && cfg_wdata[0]));

  p_ep_held_r11: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(ep_sel)));
endmodule

bind dma_burst_hs dma_hs_chk #(.CNT_W(CNT_W), .EP_W(EP_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .req_act(req_act),
  .ack_act(ack_act), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .step(step), .bytes_left(bytes_left), .ep_sel(ep_sel)
);

// File: tb/test_dma_burst_hs.sv
module test_dma_burst_hs;
  localparam int CNT_W = 16;
  localparam int EP_W  = 4;
  // {exp_bursts[8], exp_beats[8], pad[7], bus32[1], burst[8], count[16]}
  localparam int NVEC = 9;
  localparam logic [47:0] VEC [NVEC] = '{
    {8'd8,  8'd8,  7'd0, 1'b0, 8'd2,  16'd16},
    {8'd4,  8'd4,  7'd0, 1'b1, 8'd4,  16'd16},
    {8'd3,  8'd10, 7'd0, 1'b1, 8'd16, 16'd40},
    {8'd1,  8'd4,  7'd0, 1'b0, 8'd8,  16'd7},
    {8'd3,  8'd3,  7'd0, 1'b1, 8'd1,  16'd12},
    {8'd1,  8'd2,  7'd0, 1'b1, 8'd16, 16'd8},
    {8'd4,  8'd10, 7'd0, 1'b0, 8'd6,  16'd20},
    {8'd3,  8'd3,  7'd0, 1'b0, 8'd0,  16'd6},
    {8'd2,  8'd4,  7'd0, 1'b1, 8'd6,  16'd13}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_addr = '0;
  logic [CNT_W-1:0] cfg_wdata = '0;
  logic             dma_ack = 1'b0;
  logic             dma_req, busy, done, xfer_dir_wr;
  logic [EP_W-1:0]  ep_sel;
  logic [CNT_W-1:0] bytes_left;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dma_burst_hs #(.CNT_W(CNT_W), .EP_W(EP_W)) i_dma_burst_hs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dma_ack(dma_ack), .dma_req(dma_req),
    .busy(busy), .done(done), .xfer_dir_wr(xfer_dir_wr),
    .ep_sel(ep_sel), .bytes_left(bytes_left)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_xfer(input logic req_inv, input logic ack_inv,
                          output int beats, output int bursts);
    logic prev = 1'b0;
    logic act;
    int   guard = 0;
    beats = 0; bursts = 0;
    while (busy && guard < 2000) begin
      act = dma_req ^ req_inv;
      if (act && !prev) bursts++;
      if (act) beats++;
      dma_ack = act ^ ack_inv;
      prev = act;
      @(negedge clk);
      guard++;
    end
    dma_ack = ack_inv;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int beats, bursts;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 bytes_left", bytes_left, 0);
    check("R1 req idle", dma_req, 0);

    // table of transfers; odd entries use inverted pin levels (R7)
    for (int i = 0; i < NVEC; i++) begin
      logic inv;
      inv = i[0];
      wr(3'd2, CNT_W'({inv, inv, VEC[i][24]}));
      dma_ack = inv;
      wr(3'd1, CNT_W'(VEC[i][23:16]));
      wr(3'd0, VEC[i][15:0]);
      wr(3'd4, 16'h2);
      run_xfer(inv, inv, beats, bursts);
      check($sformatf("R3 beats vec%0d", i), beats, VEC[i][39:32]);
      check($sformatf("R4 R6 bursts vec%0d", i), bursts, VEC[i][47:40]);
      check($sformatf("R5 done vec%0d", i), done, 1);
      check($sformatf("R5 bytes_left vec%0d", i), bytes_left, 0);
      check($sformatf("R7 req idle level vec%0d", i), dma_req, inv);
      wr(3'd5, 16'h1);
    end

    // R7: inverted request level while idle
    wr(3'd2, 16'h6);
    check("R7 req active-low idle", dma_req, 1);
    wr(3'd2, 16'h1);
    check("R7 req active-high idle", dma_req, 0);

    // R2: start a 32-bit read, burst 4, count 12, endpoint 5
    dma_ack = 1'b0;
    wr(3'd1, 16'd4);
    wr(3'd0, 16'd12);
    wr(3'd3, 16'd5);
    wr(3'd4, 16'h1);
    check("R2 busy", busy, 1);
    check("R2 req", dma_req, 1);
    check("R2 bytes_left", bytes_left, 12);
    check("R2 ep_sel", ep_sel, 5);
    check("R2 dir read", xfer_dir_wr, 0);
    dma_ack = 1'b1;
    @(negedge clk);
    check("R3 step 4", bytes_left, 8);
    check("R4 gap req low", dma_req, 0);
    @(negedge clk);
    check("R3 ack ignored in gap", bytes_left, 8);
    check("R4 req back", dma_req, 1);
    dma_ack = 1'b0;
    @(negedge clk);
    check("R3 no ack no change", bytes_left, 8);
    wr(3'd3, 16'd9);
    check("R11 ep held", ep_sel, 5);
    wr(3'd0, 16'd100);
    wr(3'd4, 16'h2);
    check("R8 bytes_left kept", bytes_left, 8);
    check("R8 dir kept", xfer_dir_wr, 0);
    check("R8 still busy", busy, 1);
    run_xfer(1'b0, 1'b0, beats, bursts);
    check("R8 remaining beats", beats, 2);
    check("R5 done", done, 1);

    // R9: write-one-to-clear
    wr(3'd5, 16'h0);
    check("R9 zero write keeps done", done, 1);
    wr(3'd5, 16'h1);
    check("R9 clear", done, 0);

    // R10: zero count
    wr(3'd0, 16'd0);
    wr(3'd4, 16'h1);
    check("R10 done", done, 1);
    check("R10 busy", busy, 0);
    check("R10 req", dma_req, 0);
    @(negedge clk);
    check("R10 req stays idle", dma_req, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule